// File: doc/BRIEF.md
# Programmed I/O transfer controller

This block carries out the device-transfer instruction of a 12-bit accumulator machine. It takes one instruction word together with the current accumulator and program counter. If the opcode marks the word as a device transfer, the block addresses one of 64 devices and then fires up to three strobes on a shared device bus. The strobes come one after another, in a fixed order, and each one has a fixed meaning: test the device flag and skip, read device data into the accumulator, or write the accumulator to the device.

Instructions arrive on a valid/ready handshake. While a strobe sequence runs, `insn_ready` stays low, so the sender must hold the word and its operands until the block is free again. The block raises `done` for one cycle when it has finished. In that same cycle `acc_out` and `pc_out` carry the updated accumulator and program counter, and the block can already accept the next instruction. The device lines (`dev_sel`, `dev_strobe`, `dev_skip`, `dev_wdata`, `dev_rdata`) are plain signals with no handshake.

Top module: `pio_xfer_ctrl`

## Requirements
- R1: A word is a device transfer when `insn[11:9]` equals 6. A word with any other opcode is still taken by the handshake, but it produces no strobe and no `done`, and it leaves `acc_out` and `pc_out` unchanged.
- R2: `insn_ready` is high when the block is idle and in the `done` cycle, and low in every other cycle. A word is taken on a clock edge where `insn_valid` and `insn_ready` are both high. A word that is held valid while the block is busy is not taken until the block is free.
- R3: From the cycle after a transfer is taken until its `done` cycle, `dev_sel` equals `insn[8:3]` of that transfer.
- R4: The enable bits map to the strobes as follows: `insn[0]` enables `dev_strobe[0]` (skip test), `insn[1]` enables `dev_strobe[1]` (read) and `insn[2]` enables `dev_strobe[2]` (write). The enabled strobes fire in the order bit 0, bit 1, bit 2, and strobes whose bit is clear are left out. The first strobe comes in the cycle after the word is taken. Each strobe lasts exactly one cycle, and one idle cycle separates consecutive strobes. At most one strobe is high at a time.
- R5: If `dev_skip` is high during the skip-test strobe, `pc_out` at `done` is `pc_in` + 1, wrapping modulo 4096. Otherwise it is `pc_in`.
- R6: `done` is high for exactly one cycle. That cycle is the one after the last strobe, or the cycle after the word is taken if no enable bit is set.
- R7: `acc_out` at `done` is the value of `dev_rdata` sampled on the clock edge that ends the read strobe. Without a read strobe it is `acc_in`.
- R8: During the write strobe, `dev_wdata` carries the accumulator. When the read strobe is also enabled, this is the value just read.
- R9: A word offered in the `done` cycle is taken on that cycle's closing edge, and its first strobe appears in the next cycle.
- R10: During and right after reset, no strobe is high, `done` is low, `insn_ready` is high, and `acc_out` and `pc_out` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_valid | input | 1 | Instruction word and operands are offered |
| insn_ready | output | 1 | Block can take an instruction |
| insn | input | 12 | Instruction word |
| acc_in | input | 12 | Accumulator value for this instruction |
| pc_in | input | 12 | Program counter value for this instruction |
| done | output | 1 | One-cycle completion strobe |
| acc_out | output | 12 | Resulting accumulator, valid at `done` |
| pc_out | output | 12 | Resulting program counter, valid at `done` |
| dev_sel | output | 6 | Addressed device number |
| dev_strobe | output | 3 | Strobes: bit 0 skip test, bit 1 read, bit 2 write |
| dev_skip | input | 1 | Skip flag of the addressed device |
| dev_wdata | output | 12 | Data to the device |
| dev_rdata | input | 12 | Data from the device |

## Verification
Two events can fall in the same cycle: the completion of one transfer and the acceptance of the next. The bench provokes this by holding `insn_valid` high with a second word for the whole run of a first transfer. It then checks four things: the first result is intact at `done`, the second word was not taken during the strobe cycles, `dev_sel` switches to the new device, and the second sequence starts in the cycle right after that `done`. A second overlap lies inside a single transfer, where the read strobe updates the accumulator that the write strobe then drives. For this case, `dev_wdata` during the write strobe is compared with the data read two cycles earlier.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned PIO_NSTROBE = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_PULSE = 2'd1,
    SEQ_GAP   = 2'd2,
    SEQ_DONE  = 2'd3
  } seq_state_e;

  // Strobe positions inside the control field.
  localparam int unsigned STB_SKIP  = 0;
  localparam int unsigned STB_READ  = 1;
  localparam int unsigned STB_WRITE = 2;

endpackage

// File: rtl/pio_decode.sv
module pio_decode #(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned OP_W   = 3,
  parameter int unsigned SEL_W  = 6,
  parameter int unsigned IOT_OP = 6
) (
  input  logic [WORD_W-1:0]             insn,
  output logic                          is_iot,
  output logic [SEL_W-1:0]              sel,
  output logic [WORD_W-OP_W-SEL_W-1:0]  ctrl
);
  localparam int unsigned CTRL_W = WORD_W - OP_W - SEL_W;
  localparam int unsigned SEL_LO = CTRL_W;
  localparam int unsigned OP_LO  = CTRL_W + SEL_W;

  logic [OP_W-1:0] opcode;

  assign opcode = insn[OP_LO +: OP_W];
  assign is_iot = (opcode == OP_W'(IOT_OP));
  assign sel    = insn[SEL_LO +: SEL_W];
  assign ctrl   = insn[CTRL_W-1:0];

endmodule

// File: rtl/pio_sequencer.sv
module pio_sequencer
  import pio_pkg::*;
#(
  parameter int unsigned NSTB = PIO_NSTROBE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NSTB-1:0] ctrl,
  output logic            ready,
  output logic            done,
  output logic [NSTB-1:0] strobe
);

  seq_state_e      state_q, state_d;
  logic [NSTB-1:0] pend_q, pend_d;
  logic [NSTB-1:0] cur_q, cur_d;
  logic [NSTB-1:0] ctrl_low, pend_low;

  function automatic logic [NSTB-1:0] lowest_bit(input logic [NSTB-1:0] v);
    return v & (~v + NSTB'(1));
  endfunction

  assign ctrl_low = lowest_bit(ctrl);
  assign pend_low = lowest_bit(pend_q);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    cur_d   = cur_q;
    if (start) begin
      if (ctrl == '0) begin
        state_d = SEQ_DONE;
        cur_d   = '0;
        pend_d  = '0;
      end else begin
        state_d = SEQ_PULSE;
        cur_d   = ctrl_low;
        pend_d  = ctrl & ~ctrl_low;
      end
    end else begin
      unique case (state_q)
        SEQ_IDLE:  state_d = SEQ_IDLE;
        SEQ_PULSE: state_d = (pend_q == '0) ? SEQ_DONE : SEQ_GAP;
        SEQ_GAP: begin
          state_d = SEQ_PULSE;
          cur_d   = pend_low;
          pend_d  = pend_q & ~pend_low;
        end
        SEQ_DONE:  state_d = SEQ_IDLE;
        default:   state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      cur_q   <= cur_d;
    end
  end

  assign ready  = (state_q == SEQ_IDLE) || (state_q == SEQ_DONE);
  assign done   = (state_q == SEQ_DONE);
  assign strobe = (state_q == SEQ_PULSE) ? cur_q : '0;

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));                                                  // R4
  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |=> (strobe == '0));                                      // R4
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |-> !ready);                                              // R2
  AST_DONE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(|strobe) || $past(start)));                         // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);                                        // R6

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned SEL_W  = 6,
  parameter int unsigned NSTB   = PIO_NSTROBE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] pc_in,
  input  logic [NSTB-1:0]   strobe,
  input  logic              skip_flag,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] acc_q,
  output logic [WORD_W-1:0] pc_q,
  output logic [SEL_W-1:0]  sel_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      pc_q  <= '0;
      sel_q <= '0;
    end else if (start) begin
      acc_q <= acc_in;
      pc_q  <= pc_in;
      sel_q <= sel_in;
    end else begin
      if (strobe[STB_SKIP] && skip_flag) pc_q  <= pc_q + WORD_W'(1);
      if (strobe[STB_READ])              acc_q <= rdata;
    end
  end

  AST_SKIP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[STB_SKIP] && skip_flag) |=> (pc_q == WORD_W'($past(pc_q) + WORD_W'(1))));  // R5
  AST_NO_SKIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe[STB_SKIP] && !skip_flag) |=> $stable(pc_q));                // R5
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe[STB_READ] |=> (acc_q == $past(rdata)));                      // R7
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobe) |=> $stable(sel_q));                                      // R3

endmodule

// File: rtl/pio_xfer_ctrl.sv
module pio_xfer_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned WORD_W = 12,
  parameter int unsigned OP_W   = 3,
  parameter int unsigned SEL_W  = 6,
  parameter int unsigned IOT_OP = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_valid,
  output logic              insn_ready,
  input  logic [WORD_W-1:0] insn,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] pc_in,
  output logic              done,
  output logic [WORD_W-1:0] acc_out,
  output logic [WORD_W-1:0] pc_out,
  output logic [SEL_W-1:0]  dev_sel,
  output logic [WORD_W-OP_W-SEL_W-1:0] dev_strobe,
  input  logic              dev_skip,
  output logic [WORD_W-1:0] dev_wdata,
  input  logic [WORD_W-1:0] dev_rdata
);
  localparam int unsigned CTRL_W = WORD_W - OP_W - SEL_W;

  logic              is_iot;
  logic [SEL_W-1:0]  dec_sel;
  logic [CTRL_W-1:0] dec_ctrl;
  logic              accept;
  logic              start;

  pio_decode #(
    .WORD_W(WORD_W), .OP_W(OP_W), .SEL_W(SEL_W), .IOT_OP(IOT_OP)
  ) u_decode (
    .insn   (insn),
    .is_iot (is_iot),
    .sel    (dec_sel),
    .ctrl   (dec_ctrl)
  );

  assign accept = insn_valid && insn_ready;
  assign start  = accept && is_iot;

  pio_sequencer #(.NSTB(CTRL_W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .ctrl   (dec_ctrl),
    .ready  (insn_ready),
    .done   (done),
    .strobe (dev_strobe)
  );

  pio_datapath #(.WORD_W(WORD_W), .SEL_W(SEL_W), .NSTB(CTRL_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sel_in    (dec_sel),
    .acc_in    (acc_in),
    .pc_in     (pc_in),
    .strobe    (dev_strobe),
    .skip_flag (dev_skip),
    .rdata     (dev_rdata),
    .acc_q     (acc_out),
    .pc_q      (pc_out),
    .sel_q     (dev_sel)
  );

  assign dev_wdata = acc_out;

  AST_FOREIGN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !is_iot) |=> ((dev_strobe == '0) && !done));             // R1
  AST_START_FIRST_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && (dec_ctrl != '0)) |=> (|dev_strobe));                     // R4

endmodule

// File: tb/pio_xfer_ctrl_tb_top.sv
module pio_xfer_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        insn_valid;
  logic        insn_ready;
  logic [11:0] insn, acc_in, pc_in;
  logic        done;
  logic [11:0] acc_out, pc_out;
  logic [5:0]  dev_sel;
  logic [2:0]  dev_strobe;
  logic        dev_skip;
  logic [11:0] dev_wdata, dev_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [11:0] last_acc, last_pc;

  always #2 clk = ~clk;

  pio_xfer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .insn_valid(insn_valid), .insn_ready(insn_ready), .insn(insn),
    .acc_in(acc_in), .pc_in(pc_in),
    .done(done), .acc_out(acc_out), .pc_out(pc_out),
    .dev_sel(dev_sel), .dev_strobe(dev_strobe), .dev_skip(dev_skip),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_iot(input logic [5:0] sel, input logic [2:0] ctrl,
                         input logic [11:0] acc, input logic [11:0] pc,
                         input logic skip, input logic [11:0] rdata);
    int ord[3];
    int n = 0;
    int done_cyc;
    logic [11:0] exp_acc, exp_pc;
    for (int b = 0; b < 3; b++) if (ctrl[b]) begin ord[n] = b; n++; end
    done_cyc = (n == 0) ? 1 : 2 * n;
    exp_pc  = (ctrl[0] && skip) ? pc + 12'd1 : pc;
    exp_acc = ctrl[1] ? rdata : acc;
    @(negedge clk);
    insn_valid = 1'b1; insn = {3'd6, sel, ctrl};
    acc_in = acc; pc_in = pc; dev_skip = skip; dev_rdata = rdata;
    @(posedge clk); #1 insn_valid = 1'b0;
    for (int k = 1; k <= done_cyc; k++) begin
      logic [2:0] exp_stb;
      @(negedge clk);
      exp_stb = ((k % 2 == 1) && ((k - 1) / 2 < n)) ? (3'b001 << ord[(k - 1) / 2]) : 3'b000;
      chk("R4 strobe order/timing", dev_strobe, exp_stb);
      chk("R6 done timing", done, k == done_cyc);
      chk("R2 ready while busy", insn_ready, k == done_cyc);
      chk("R3 device select", dev_sel, sel);
      if (exp_stb[2]) chk("R8 write data", dev_wdata, exp_acc);
    end
    chk("R7 accumulator result", acc_out, exp_acc);
    chk("R5 program counter result", pc_out, exp_pc);
    @(negedge clk);
    chk("R6 done single cycle", done, 0);
    last_acc = exp_acc; last_pc = exp_pc;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; insn_valid = 1'b0; insn = '0; acc_in = '0; pc_in = '0;
    dev_skip = 1'b0; dev_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 strobe in reset", dev_strobe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 strobe after reset", dev_strobe, 0);
    chk("R10 done after reset", done, 0);
    chk("R10 ready after reset", insn_ready, 1);
    chk("R10 acc after reset", acc_out, 0);
    chk("R10 pc after reset", pc_out, 0);
  endtask

  task automatic t_foreign();
    @(negedge clk);
    insn_valid = 1'b1; insn = {3'd5, 6'o12, 3'b111}; acc_in = 12'o1234; pc_in = 12'o4321;
    @(posedge clk); #1 insn_valid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      chk("R1 no strobe for other opcode", dev_strobe, 0);
      chk("R1 no done for other opcode", done, 0);
      chk("R2 ready stays high", insn_ready, 1);
    end
    chk("R1 acc unchanged", acc_out, last_acc);
    chk("R1 pc unchanged", pc_out, last_pc);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    insn_valid = 1'b1; insn = {3'd6, 6'o21, 3'b001};
    acc_in = 12'o0707; pc_in = 12'o0100; dev_skip = 1'b1; dev_rdata = 12'o5555;
    @(posedge clk); #1;
    insn = {3'd6, 6'o42, 3'b010}; acc_in = 12'o0001; pc_in = 12'o0200;
    @(negedge clk);
    chk("R2 held word not taken", insn_ready, 0);
    chk("R9 first strobe A", dev_strobe, 3'b001);
    chk("R3 select A", dev_sel, 6'o21);
    @(negedge clk);
    chk("R9 done A", done, 1);
    chk("R9 ready in done", insn_ready, 1);
    chk("R9 pc A intact", pc_out, 12'o0101);
    chk("R9 acc A intact", acc_out, 12'o0707);
    @(posedge clk); #1 insn_valid = 1'b0;
    @(negedge clk);
    chk("R9 B starts next cycle", dev_strobe, 3'b010);
    chk("R9 select B", dev_sel, 6'o42);
    @(negedge clk);
    chk("R9 done B", done, 1);
    chk("R9 acc B", acc_out, 12'o5555);
    chk("R9 pc B", pc_out, 12'o0200);
    @(negedge clk);
    last_acc = 12'o5555; last_pc = 12'o0200;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    run_iot(6'o00, 3'b000, 12'o1111, 12'o0010, 1'b1, 12'o2222); // R6 no enable bits
    run_iot(6'o07, 3'b001, 12'o1111, 12'o0020, 1'b1, 12'o2222); // R5 skip taken
    run_iot(6'o10, 3'b001, 12'o1111, 12'o0030, 1'b0, 12'o2222); // R5 skip not taken
    run_iot(6'o33, 3'b010, 12'o1111, 12'o0040, 1'b1, 12'o3456); // R7 read
    run_iot(6'o77, 3'b100, 12'o6543, 12'o0050, 1'b1, 12'o3456); // R8 write
    run_iot(6'o55, 3'b110, 12'o6543, 12'o0060, 1'b0, 12'o7012); // R8 read then write
    run_iot(6'o01, 3'b101, 12'o0101, 12'o0070, 1'b1, 12'o7012); // R4 skip then write
    run_iot(6'o46, 3'b111, 12'o0101, 12'o7777, 1'b1, 12'o4000); // R5 wrap, all strobes
    t_foreign();
    t_back_to_back();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule